// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target

This block is a two-wire serial bus target that fronts a 256-entry, 8-bit byte array. It watches a bus clock line and a bus data line, both sampled in the system clock domain through a short synchroniser. From those samples it picks out start, repeated start and stop conditions. It matches a 7-bit device address whose upper four bits are fixed at binary 1010 and whose lower three bits come from strap pins. It then either takes a one-byte word address and an optional data byte (a write), or shifts stored bytes out to the bus controller (a read).

An 8-bit pointer lives inside the block and survives from one transaction to the next. A read with no address phase starts from that pointer. A random read is built by sending a write-mode header and a word address, then abandoning the write with a repeated start and a read-mode header. A read keeps going for as long as the controller acknowledges each byte, and the pointer wraps from the top of the array to zero. The data line is shown as a pull-low enable plus the sampled line level, so the surrounding wired-AND is modelled outside the block.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the pull-low enable is 0, the pointer is 0 and every byte is 0, so a read with no address phase returns 0x00.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Either one aborts the byte in progress and releases the data line. A start returns the block to address receive. A data-line change seen in the same sample as a clock fall is not a condition.
- R3: The header byte is sent MSB first and carries {4'b1010, strap[2:0], rw}. A match is acknowledged by pulling data low on the ninth clock. A mismatch gets no acknowledge, the data line is never driven, and nothing is written until the next start.
- R4: In a write-mode transaction the second byte becomes the pointer. A third byte is stored at that address and leaves the pointer at that address plus one.
- R5: A read-mode header with no address phase returns the byte at the pointer, which is the last accessed address plus one. Above 0xFF this wraps to 0x00.
- R6: A write-mode header plus a word address, followed by a repeated start and a read-mode header, returns the byte at that word address and writes nothing.
- R7: Each controller acknowledge of a read byte makes the block send the next byte, incrementing the pointer by one per byte and rolling from 0xFF to 0x00 without a gap.
- R8: A controller not-acknowledge (data high on the ninth clock) ends the read. The block then keeps the data line released through any further clocks until a start or stop.
- R9: The block changes its pull-low enable only while the clock line is low, samples incoming bits on the clock rising edge and sends bits MSB first.
- R10: A stop or start that arrives before the eighth bit of a data byte stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
Decoding a data-line change as a start or stop can collide with the normal shifting of a bit when the controller moves the data line in the same system-clock sample in which the clock line falls. The bench provokes this by sending a complete write with every data transition made together with the clock fall. It then reads the stored byte back and requires it to be intact. A phantom condition would abort the byte, so the read-back would return the old contents. The bus conditions themselves are also placed in the middle of bytes, and the bench requires that the address-receive state is entered with nothing stored.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    parameter int unsigned MEM_AW = 8;
    parameter int unsigned MEM_DW = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RXEND,
        S_ACK,
        S_TX,
        S_MACK,
        S_MNEXT,
        S_WAIT
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WORD,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s;

    // stage 0 takes the raw line, later stages chain
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_sr_q[0] <= 1'b1;
                        sda_sr_q[0] <= 1'b1;
                    end else begin
                        scl_sr_q[0] <= scl_i;
                        sda_sr_q[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_sr_q[g] <= 1'b1;
                        sda_sr_q[g] <= 1'b1;
                    end else begin
                        scl_sr_q[g] <= scl_sr_q[g-1];
                        sda_sr_q[g] <= sda_sr_q[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_sr_q[LAST];
            sda_p_q <= sda_sr_q[LAST];
        end
    end

    assign scl_s     = scl_sr_q[LAST];
    assign sda_s     = sda_sr_q[LAST];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    // clock high in both samples: a data edge is a bus condition
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else if (we && (addr == AW'(g))) begin
                    mem_q[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem_q[addr];

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_mem_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 8,
    parameter logic [3:0]  DEV_HI = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [2:0]    strap_i,
    input  logic [DW-1:0] rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rd_load,
    output logic          sda_oe,
    output logic [AW-1:0] ptr_o
);

    localparam int unsigned CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        tgt_state_e    st;
        rx_phase_e     ph;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          rw;
        logic          ack;
        logic          oe;
        logic [AW-1:0] ptr;
    } ctl_t;

    ctl_t          d, q;
    logic [DW-1:0] byte_in;
    logic [6:0]    dev_id;

    assign byte_in = {q.sh[DW-2:0], sda_s};
    assign dev_id  = {DEV_HI, strap_i};

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        rd_load = 1'b0;
        if (stop_det) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = S_RX;
            d.ph  = PH_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.st = S_RXEND;
                            case (q.ph)
                                PH_ADDR: begin
                                    d.ack = (byte_in[DW-1:1] == dev_id);
                                    d.rw  = byte_in[0];
                                end
                                PH_WORD: begin
                                    d.ptr = AW'(byte_in);
                                    d.ack = 1'b1;
                                end
                                default: begin
                                    mem_we = 1'b1;
                                    d.ptr  = q.ptr + 1'b1;
                                    d.ack  = 1'b1;
                                end
                            endcase
                        end
                    end
                end
                S_RXEND: begin
                    if (scl_fall) begin
                        if (q.ack) begin
                            d.st = S_ACK;
                            d.oe = 1'b1;
                        end else begin
                            d.st = S_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.ph == PH_ADDR && q.rw) begin
                            rd_load = 1'b1;
                            d.sh    = rd_data;
                            d.ptr   = q.ptr + 1'b1;
                            d.oe    = ~rd_data[DW-1];
                            d.st    = S_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_RX;
                            d.ph = (q.ph == PH_ADDR) ? PH_WORD : PH_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = S_MACK;
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                            d.oe  = ~q.sh[DW-2];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.st = sda_s ? S_WAIT : S_MNEXT;
                    end
                end
                S_MNEXT: begin
                    if (scl_fall) begin
                        rd_load = 1'b1;
                        d.sh    = rd_data;
                        d.ptr   = q.ptr + 1'b1;
                        d.oe    = ~rd_data[DW-1];
                        d.cnt   = '0;
                        d.st    = S_TX;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ph: PH_ADDR, cnt: '0, sh: '0, rw: 1'b0,
                   ack: 1'b0, oe: 1'b0, ptr: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.ptr;
    assign mem_wdata = byte_in;
    assign sda_oe    = q.oe;
    assign ptr_o     = q.ptr;

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
    parameter int unsigned ADDR_W      = i2c_mem_pkg::MEM_AW,
    parameter int unsigned DATA_W      = i2c_mem_pkg::MEM_DW,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_HI      = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we, rd_load;
    logic [ADDR_W-1:0] mem_addr, ptr;
    logic [DATA_W-1:0] mem_wdata, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_ctrl #(.AW(ADDR_W), .DW(DATA_W), .DEV_HI(DEV_HI)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .rd_data   (rd_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_load   (rd_load),
        .sda_oe    (sda_oe_o),
        .ptr_o     (ptr)
    );

    i2c_byte_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input logic          start_det,
    input logic          stop_det,
    input logic          mem_we,
    input logic          rd_load,
    input logic [AW-1:0] ptr
);

    a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    a_r4_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(ptr) + AW'(1)));

    a_r4_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !sda_oe_o);

    a_r7_load_advances: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ptr == $past(ptr) + AW'(1)));

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_we    (mem_we),
    .rd_load   (rd_load),
    .ptr       (ptr)
);

// File: tb/sim_i2c_mem_target.sv
`timescale 1ns/1ps
module sim_i2c_mem_target;

    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [2:0] BAD   = 3'b100;
    localparam logic [6:0] DEV   = {4'b1010, STRAP};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int tests = 0;
    int fails = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    logic [7:0] model [256];
    logic [7:0] mptr = 8'h00;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_target u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && (oe_prev !== sda_oe) && scl_m) r9_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // returns 1 in ack when the target pulled the line low on the ninth clock
    task automatic send_byte(input logic [7:0] b, input bit tight, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            if (!tight || i == 7) sda_m = b[i];
            wq(); scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
            if (tight) sda_m = (i > 0) ? b[i-1] : 1'b1;
            wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v, input bit tight, input string req);
        bit k0, k1, k2;
        bus_start();
        send_byte({DEV, 1'b0}, tight, k0);
        send_byte(a, tight, k1);
        send_byte(v, tight, k2);
        bus_stop();
        chk({req, " acks"}, {k0, k1, k2}, 3'b111);
        model[a] = v;
        mptr = a + 8'd1;
    endtask

    task automatic do_random(input logic [7:0] a, input int n, input string req);
        bit k0, k1, k2;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, k0);
        send_byte(a, 1'b0, k1);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, k2);
        chk({req, " acks"}, {k0, k1, k2}, 3'b111);
        mptr = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(req, b, model[mptr]);
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic do_current(input string req);
        bit k0;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, k0);
        recv_byte(b, 1'b0);
        bus_stop();
        chk({req, " ack"}, k0, 1'b1);
        chk(req, b, model[mptr]);
        mptr = mptr + 8'd1;
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", sda_oe, 1'b0);
        do_current("R1 first read at pointer 0");
    endtask

    task automatic t_preload();
        do_write(8'h10, 8'h3C, 1'b0, "R4 preload");
        do_write(8'h11, 8'hA5, 1'b0, "R4 preload");
        do_write(8'h12, 8'h96, 1'b0, "R4 preload");
        do_write(8'hFE, 8'h81, 1'b0, "R4 preload");
        do_write(8'hFF, 8'h7E, 1'b0, "R4 preload");
        do_write(8'h00, 8'h5A, 1'b0, "R4 preload");
        do_write(8'h01, 8'hC3, 1'b0, "R4 preload");
    endtask

    task automatic t_random();
        do_random(8'h11, 1, "R6/R9 random read");
        do_random(8'hFE, 1, "R6 random read top");
        do_random(8'h10, 1, "R6 dummy write stored nothing");
    endtask

    task automatic t_write_then_current();
        do_write(8'h10, 8'h3C, 1'b0, "R4 write");
        do_current("R4 pointer left at address plus one");
        do_current("R5 current read continues");
    endtask

    task automatic t_wrap_current();
        do_write(8'hFF, 8'h7E, 1'b0, "R5 write top");
        do_current("R5 current read wraps to 0");
    endtask

    task automatic t_sequential();
        do_random(8'h10, 3, "R7 sequential");
        do_random(8'hFE, 4, "R7 sequential rollover");
        do_current("R7 pointer after burst");
    endtask

    task automatic t_mismatch();
        bit k0, k1, k2;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, BAD, 1'b0}, 1'b0, k0);
        send_byte(8'h10, 1'b0, k1);
        send_byte(8'h99, 1'b0, k2);
        bus_stop();
        chk("R3 mismatch no acks", {k0, k1, k2}, 3'b000);
        bus_start();
        send_byte({4'b1010, BAD, 1'b1}, 1'b0, k0);
        recv_byte(b, 1'b0);
        bus_stop();
        chk("R3 mismatch read no ack", k0, 1'b0);
        chk("R3 mismatch read line undriven", b, 8'hFF);
        do_random(8'h10, 1, "R3 mismatch wrote nothing");
    endtask

    task automatic t_nack_release();
        logic [7:0] b;
        bit k0, k1, k2;
        int low = 0;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, k0);
        send_byte(8'h11, 1'b0, k1);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, k2);
        recv_byte(b, 1'b0);
        chk("R8 byte before nack", b, model[8'h11]);
        for (int i = 0; i < 9; i++) begin
            wq(); scl_m = 1'b1; wq();
            if (sda_line == 1'b0) low++;
            wq(); scl_m = 1'b0;
        end
        bus_stop();
        chk("R8 released after nack", low, 0);
        mptr = 8'h12;
        do_current("R8 pointer after nack");
    endtask

    task automatic t_stop_abort();
        bit k0, k1;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, k0);
        send_byte(8'h12, 1'b0, k1);
        send_bits(8'h00, 4);
        bus_stop();
        chk("R10 acks before abort", {k0, k1}, 2'b11);
        do_random(8'h12, 1, "R10 stop mid byte stored nothing");
    endtask

    task automatic t_start_abort();
        bit k0, k1, k2;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, k0);
        send_byte(8'h01, 1'b0, k1);
        send_bits(8'h00, 3);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, k2);
        recv_byte(b, 1'b0);
        bus_stop();
        chk("R2 start mid byte acks", {k0, k1, k2}, 3'b111);
        chk("R2 start mid byte back to address", b, model[8'h01]);
        mptr = 8'h02;
    endtask

    task automatic t_tight();
        do_write(8'h40, 8'hB7, 1'b1, "R2 coincident edges");
        do_random(8'h40, 1, "R2 coincident write read back");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_preload();
        t_random();
        t_write_then_current();
        t_wrap_current();
        t_sequential();
        t_mismatch();
        t_nack_release();
        t_stop_abort();
        t_start_abort();
        t_tight();
        chk("R9 pull-low changes only with clock low", r9_viol, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule